// File: doc/BRIEF.md
# Lock-Aware Replacement Way Selector

This block chooses which way of a four-way set-associative cache is overwritten when a lookup misses. It holds a true least-recently-used order for every set and refreshes it whenever a way is hit or refilled. Ways 2 and 3 can be pinned so that ordinary misses never take them. In that case the choice narrows to the least recently used of the ways still open.

A cache-wide lock enable gates every pin and steering bit. When the enable is low, the selector falls back to plain LRU over all four ways. When the enable is high and a pinned way also has its load bit set, a prefetch miss is sent straight into that way. This lets software preload a locked region. Setting both load bits together is an illegal setting: the block flags it and then acts as if neither load bit were set.

The victim is registered and appears one clock after the miss strobe. The same clock edge marks the chosen way as most recently used in the addressed set.

Top module: `lock_victim_sel`

## Requirements
- R1: After reset `victim_vld` and `cfg_err` are 0, and every set holds the order way 0 (oldest), 1, 2, 3 (newest). So a run of plain misses on an untouched set picks ways 0, 1, 2, 3, 0.
- R2: `victim_vld` is 1 exactly in the cycle after a cycle with `miss_vld` high. In that cycle `victim_way` holds the chosen way, encoded as its binary number.
- R3: While `lock_en` is 0, the victim is the least recently used of all four ways, whatever `ctrl_word` and `pref_miss` hold.
- R4: A hit (`hit_vld`, `hit_way`) makes that way the most recent in set `set_idx`, and so does the way chosen on a miss. The victim is always the least recent way among those allowed.
- R5: With `lock_en` 1 and `ctrl_word[0]` (way-2 pin) set, way 2 is never chosen unless steering per R8 applies. With `ctrl_word[8]` clear, the choice is the least recent of ways 0, 1 and 3.
- R6: With `lock_en` 1 and `ctrl_word[8]` (way-3 pin) set, way 3 is never chosen unless steering per R9 applies. With `ctrl_word[0]` clear, the choice is the least recent of ways 0, 1 and 2.
- R7: With `lock_en` 1 and both pins set and no steering, the victim is the less recent of ways 0 and 1.
- R8: A miss with `pref_miss` 1, `lock_en` 1, `ctrl_word[0]` and `ctrl_word[1]` (way-2 load) set, and `ctrl_word[9]` clear picks way 2.
- R9: A miss with `pref_miss` 1, `lock_en` 1, `ctrl_word[8]` and `ctrl_word[9]` (way-3 load) set, and `ctrl_word[1]` clear picks way 3.
- R10: A load bit has no effect on a non-prefetch miss. A load bit whose way is not pinned also has no effect on a prefetch miss.
- R11: `cfg_err` is 1 in the cycle after any cycle where `ctrl_word[1]` and `ctrl_word[9]` are both 1, and 0 otherwise. While both are set, both load bits are treated as 0.
- R12: Each set keeps its own order. When `miss_vld` and `hit_vld` are high in the same cycle, the hit is ignored and only the miss updates the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctrl_word | input | CTRL_W | Pin and load bits: 0 pin way 2, 1 load way 2, 8 pin way 3, 9 load way 3 |
| lock_en | input | 1 | Cache-wide lock enable |
| miss_vld | input | 1 | Miss strobe for set `set_idx` |
| pref_miss | input | 1 | The miss comes from a prefetch |
| set_idx | input | SET_W | Set addressed by the hit or miss |
| hit_vld | input | 1 | Hit strobe |
| hit_way | input | 2 | Way that hit |
| victim_vld | output | 1 | Victim valid, one cycle after `miss_vld` |
| victim_way | output | 2 | Chosen way |
| cfg_err | output | 1 | Both load bits were set in the previous cycle |

## Verification
Each lock setting is tried on its own set after a hit sequence that leaves the excluded way oldest. A wrong choice there cannot hide behind the reset order. Disabled-lock runs reuse pin and steer words that would change the answer if they were obeyed, and prefetch misses are compared with ordinary misses under the same word. This separates steering from pinning. A simultaneous hit and miss, with a different way in each, shows whether the hit leaks into the order. A long mixed run then compares every victim with a timestamp model across all lock settings.

// File: rtl/lvs_pkg.sv
package lvs_pkg;
  localparam int NUM_WAYS = 4;
  localparam int PAIRS    = NUM_WAYS * (NUM_WAYS - 1) / 2;

  localparam int PIN_W2_POS  = 0;
  localparam int LOAD_W2_POS = 1;
  localparam int PIN_W3_POS  = 8;
  localparam int LOAD_W3_POS = 9;

  typedef logic [1:0]          way_t;
  typedef logic [PAIRS-1:0]    order_t;
  typedef logic [NUM_WAYS-1:0] wmask_t;

  // bit position of the pair (a,b), a < b; bit set = way a used after way b
  function automatic int pair_pos(input int a, input int b);
    int p;
    p = 0;
    for (int i = 0; i < a; i++) p = p + (NUM_WAYS - 1 - i);
    return p + (b - a - 1);
  endfunction

  // true when way k was used more recently than way w
  function automatic logic is_newer(input order_t o, input int k, input int w);
    if (k < w) return o[pair_pos(k, w)];
    else       return !o[pair_pos(w, k)];
  endfunction

  // mark way w as most recently used
  function automatic order_t touch(input order_t o, input way_t w);
    order_t r;
    r = o;
    for (int a = 0; a < NUM_WAYS; a++) begin
      for (int b = a + 1; b < NUM_WAYS; b++) begin
        if (a == int'(w)) r[pair_pos(a, b)] = 1'b1;
        if (b == int'(w)) r[pair_pos(a, b)] = 1'b0;
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/lvs_steer_decode.sv
module lvs_steer_decode
  import lvs_pkg::*;
(
  input  logic   pin_w2,
  input  logic   load_w2,
  input  logic   pin_w3,
  input  logic   load_w3,
  input  logic   lock_en,
  input  logic   pref_miss,
  output wmask_t allow,
  output logic   force_vld,
  output way_t   force_way,
  output logic   load_clash
);
  logic ld2_eff;
  logic ld3_eff;
  logic steer2;
  logic steer3;

  always_comb begin
    load_clash = load_w2 & load_w3;
    ld2_eff    = load_w2 & ~load_clash;
    ld3_eff    = load_w3 & ~load_clash;
    steer2     = lock_en & pref_miss & pin_w2 & ld2_eff;
    steer3     = lock_en & pref_miss & pin_w3 & ld3_eff;
  end

  always_comb begin
    if (lock_en) begin
      allow = {~pin_w3, ~pin_w2, 2'b11};
    end else begin
      allow = '1;
    end
    force_vld = steer2 | steer3;
    force_way = steer3 ? way_t'(3) : way_t'(2);
  end
endmodule

// File: rtl/lvs_victim_pick.sv
module lvs_victim_pick
  import lvs_pkg::*;
(
  input  order_t order,
  input  wmask_t allow,
  output way_t   pick
);
  wmask_t oldest;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    logic is_old;
    always_comb begin
      is_old = allow[w];
      for (int k = 0; k < NUM_WAYS; k++) begin
        if (k != w && allow[k] && !is_newer(order, k, w)) is_old = 1'b0;
      end
    end
    assign oldest[w] = is_old;
  end

  always_comb begin
    pick = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (oldest[w]) pick = way_t'(w);
    end
  end
endmodule

// File: rtl/lvs_lru_store.sv
module lvs_lru_store
  import lvs_pkg::*;
#(
  parameter  int NUM_SETS = 16,
  localparam int SET_W    = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] rd_idx,
  output order_t           rd_order,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_idx,
  input  way_t             wr_way
);
  order_t rows [NUM_SETS];

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    order_t row_q;
    order_t row_d;
    logic   row_en;

    always_comb begin
      row_en = wr_en && (wr_idx == SET_W'(s));
      row_d  = touch(row_q, wr_way);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        row_q <= '0;
      end else if (row_en) begin
        row_q <= row_d;
      end
    end

    assign rows[s] = row_q;
  end

  assign rd_order = rows[rd_idx];
endmodule

// File: rtl/lock_victim_sel.sv
module lock_victim_sel
  import lvs_pkg::*;
#(
  parameter  int NUM_SETS = 16,
  parameter  int CTRL_W   = 16,
  localparam int SET_W    = $clog2(NUM_SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic              lock_en,
  input  logic              miss_vld,
  input  logic              pref_miss,
  input  logic [SET_W-1:0]  set_idx,
  input  logic              hit_vld,
  input  logic [1:0]        hit_way,
  output logic              victim_vld,
  output logic [1:0]        victim_way,
  output logic              cfg_err
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  logic       unused_ctrl;

  order_t set_order;
  wmask_t allow;
  logic   force_vld;
  way_t   force_way;
  logic   load_clash;
  way_t   lru_way;
  way_t   victim_c;
  logic   upd_en;
  way_t   upd_way;

  logic   victim_vld_q, victim_vld_d;
  way_t   victim_way_q, victim_way_d;
  logic   cfg_err_q, cfg_err_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_core_n  = rst_sync_q[1];
  assign unused_ctrl = ^ctrl_word;

  lvs_lru_store #(.NUM_SETS(NUM_SETS)) i_store (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .rd_idx   (set_idx),
    .rd_order (set_order),
    .wr_en    (upd_en),
    .wr_idx   (set_idx),
    .wr_way   (upd_way)
  );

  lvs_steer_decode i_decode (
    .pin_w2     (ctrl_word[PIN_W2_POS]),
    .load_w2    (ctrl_word[LOAD_W2_POS]),
    .pin_w3     (ctrl_word[PIN_W3_POS]),
    .load_w3    (ctrl_word[LOAD_W3_POS]),
    .lock_en    (lock_en),
    .pref_miss  (pref_miss),
    .allow      (allow),
    .force_vld  (force_vld),
    .force_way  (force_way),
    .load_clash (load_clash)
  );

  lvs_victim_pick i_pick (
    .order (set_order),
    .allow (allow),
    .pick  (lru_way)
  );

  always_comb begin
    victim_c     = force_vld ? force_way : lru_way;
    upd_en       = miss_vld | hit_vld;
    upd_way      = miss_vld ? victim_c : way_t'(hit_way);
    victim_vld_d = miss_vld;
    victim_way_d = miss_vld ? victim_c : victim_way_q;
    cfg_err_d    = load_clash;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      victim_vld_q <= 1'b0;
      victim_way_q <= '0;
      cfg_err_q    <= 1'b0;
    end else begin
      victim_vld_q <= victim_vld_d;
      victim_way_q <= victim_way_d;
      cfg_err_q    <= cfg_err_d;
    end
  end

  assign victim_vld = victim_vld_q;
  assign victim_way = victim_way_q;
  assign cfg_err    = cfg_err_q;
endmodule

// File: rtl/lvs_checker.sv
module lvs_checker #(
  parameter int CTRL_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CTRL_W-1:0] ctrl_word,
  input logic              lock_en,
  input logic              miss_vld,
  input logic              pref_miss,
  input logic              victim_vld,
  input logic [1:0]        victim_way,
  input logic              cfg_err
);
  logic pin2, ld2, pin3, ld3;
  assign pin2 = ctrl_word[0];
  assign ld2  = ctrl_word[1];
  assign pin3 = ctrl_word[8];
  assign ld3  = ctrl_word[9];

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r1: assert (!victim_vld && !cfg_err);
    end
  end

  p_vld_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    miss_vld |=> victim_vld);
  p_vld_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_vld |=> !victim_vld);
  p_keep_way2_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_vld && lock_en && pin2 && !(pref_miss && ld2 && !ld3)) |=> victim_way != 2'd2);
  p_keep_way3_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_vld && lock_en && pin3 && !(pref_miss && ld3 && !ld2)) |=> victim_way != 2'd3);
  p_low_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_vld && lock_en && pin2 && pin3 && !(pref_miss && (ld2 ^ ld3))) |=> !victim_way[1]);
  p_steer_way2_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_vld && lock_en && pref_miss && pin2 && ld2 && !ld3) |=> victim_way == 2'd2);
  p_steer_way3_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_vld && lock_en && pref_miss && pin3 && ld3 && !ld2) |=> victim_way == 2'd3);
  p_clash_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ld2 && ld3) |=> cfg_err);
  p_clash_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld2 && ld3) |=> !cfg_err);
endmodule

bind lock_victim_sel lvs_checker #(.CTRL_W(CTRL_W)) i_lvs_checker (
  .clk        (clk),
  .rst_n      (rst_core_n),
  .ctrl_word  (ctrl_word),
  .lock_en    (lock_en),
  .miss_vld   (miss_vld),
  .pref_miss  (pref_miss),
  .victim_vld (victim_vld),
  .victim_way (victim_way),
  .cfg_err    (cfg_err)
);

// File: tb/test_lock_victim_sel.sv
`timescale 1ns/1ps
module test_lock_victim_sel;
  localparam int NSETS = 16;
  localparam int SW    = $clog2(NSETS);

  logic          clk;
  logic          rst_n;
  logic [15:0]   ctrl_word;
  logic          lock_en;
  logic          miss_vld;
  logic          pref_miss;
  logic [SW-1:0] set_idx;
  logic          hit_vld;
  logic [1:0]    hit_way;
  logic          victim_vld;
  logic [1:0]    victim_way;
  logic          cfg_err;

  int checks = 0;
  int fails  = 0;
  int stamp [NSETS][4];
  int tnow;

  lock_victim_sel #(.NUM_SETS(NSETS), .CTRL_W(16)) i_lock_victim_sel (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .lock_en(lock_en),
    .miss_vld(miss_vld), .pref_miss(pref_miss), .set_idx(set_idx),
    .hit_vld(hit_vld), .hit_way(hit_way), .victim_vld(victim_vld),
    .victim_way(victim_way), .cfg_err(cfg_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check_val(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // reference: timestamp per way, smallest stamp is least recent
  function automatic int ref_pick(input int s, input logic [15:0] cw, input logic en, input logic pf);
    logic       clash;
    logic [3:0] ok_m;
    int         best;
    clash = cw[1] & cw[9];
    ok_m  = 4'hF;
    if (en) begin
      if (pf && cw[0] && cw[1] && !clash) return 2;
      if (pf && cw[8] && cw[9] && !clash) return 3;
      ok_m[2] = !cw[0];
      ok_m[3] = !cw[8];
    end
    best = -1;
    for (int w = 0; w < 4; w++)
      if (ok_m[w] && (best < 0 || stamp[s][w] < stamp[s][best])) best = w;
    return best;
  endfunction

  task automatic do_miss(input int s, input logic [15:0] cw, input logic en, input logic pf,
                         input string req, input int want = -1);
    int exp;
    exp = (want >= 0) ? want : ref_pick(s, cw, en, pf);
    @(negedge clk);
    miss_vld = 1'b1; pref_miss = pf; lock_en = en; ctrl_word = cw; set_idx = SW'(s);
    @(negedge clk);
    miss_vld = 1'b0; pref_miss = 1'b0;
    check_val(req, "victim_vld", int'(victim_vld), 1);
    check_val(req, "victim_way", int'(victim_way), exp);
    stamp[s][exp] = tnow; tnow++;
  endtask

  task automatic do_hit(input int s, input int w);
    @(negedge clk);
    hit_vld = 1'b1; set_idx = SW'(s); hit_way = 2'(w);
    @(negedge clk);
    hit_vld = 1'b0;
    stamp[s][w] = tnow; tnow++;
  endtask

  task automatic t_reset;
    check_val("R1", "victim_vld after reset", int'(victim_vld), 0);
    check_val("R1", "cfg_err after reset", int'(cfg_err), 0);
    do_miss(0, 16'h0000, 1'b1, 1'b0, "R1", 0);
    do_miss(0, 16'h0000, 1'b1, 1'b0, "R1", 1);
    do_miss(0, 16'h0000, 1'b1, 1'b0, "R1", 2);
    do_miss(0, 16'h0000, 1'b1, 1'b0, "R1", 3);
    do_miss(0, 16'h0000, 1'b1, 1'b0, "R1", 0);
    @(negedge clk);
    check_val("R2", "victim_vld idle", int'(victim_vld), 0);
  endtask

  task automatic t_disabled;
    do_hit(1, 0); do_hit(1, 1); do_hit(1, 2);
    do_miss(1, 16'h0100, 1'b0, 1'b0, "R3", 3);
    do_miss(1, 16'h0301, 1'b0, 1'b1, "R3", 0);
  endtask

  task automatic t_hit_order;
    do_hit(2, 3); do_hit(2, 0); do_hit(2, 2);
    do_miss(2, 16'h0000, 1'b1, 1'b0, "R4", 1);
    do_hit(2, 3);
    do_miss(2, 16'h0000, 1'b1, 1'b0, "R4", 0);
  endtask

  task automatic t_pin2;
    do_hit(3, 0); do_hit(3, 1);
    do_miss(3, 16'h0001, 1'b1, 1'b0, "R5", 3);
    do_miss(3, 16'h0001, 1'b1, 1'b0, "R5", 0);
    for (int n = 0; n < 4; n++) do_miss(3, 16'h0001, 1'b1, 1'b0, "R5");
  endtask

  task automatic t_pin3;
    do_hit(4, 0); do_hit(4, 1); do_hit(4, 2);
    do_miss(4, 16'h0100, 1'b1, 1'b0, "R6", 0);
    for (int n = 0; n < 4; n++) do_miss(4, 16'h0100, 1'b1, 1'b0, "R6");
  endtask

  task automatic t_pin_both;
    do_hit(5, 0); do_hit(5, 1);
    do_miss(5, 16'h0101, 1'b1, 1'b0, "R7", 0);
    do_miss(5, 16'h0101, 1'b1, 1'b0, "R7", 1);
    do_miss(5, 16'h0101, 1'b1, 1'b0, "R7", 0);
  endtask

  task automatic t_steer2;
    do_miss(6, 16'h0003, 1'b1, 1'b1, "R8", 2);
    do_miss(6, 16'h0003, 1'b1, 1'b1, "R8", 2);
    do_miss(6, 16'h0103, 1'b1, 1'b1, "R8", 2);
    do_miss(6, 16'h0003, 1'b1, 1'b0, "R10 ordinary miss", 0);
  endtask

  task automatic t_steer3;
    do_miss(8, 16'h0300, 1'b1, 1'b1, "R9", 3);
    do_miss(8, 16'h0301, 1'b1, 1'b1, "R9", 3);
    do_miss(8, 16'h0200, 1'b1, 1'b1, "R10 load without pin", 0);
  endtask

  task automatic t_clash;
    do_miss(9, 16'h0303, 1'b1, 1'b1, "R11 fallback", 0);
    check_val("R11", "cfg_err set", int'(cfg_err), 1);
    @(negedge clk); ctrl_word = 16'h0202; lock_en = 1'b0;
    @(negedge clk);
    check_val("R11", "cfg_err set, lock off", int'(cfg_err), 1);
    ctrl_word = 16'h0002;
    @(negedge clk);
    check_val("R11", "cfg_err clear", int'(cfg_err), 0);
  endtask

  task automatic t_sets;
    @(negedge clk);
    miss_vld = 1'b1; hit_vld = 1'b1; hit_way = 2'd1; set_idx = SW'(7);
    lock_en = 1'b1; ctrl_word = 16'h0000; pref_miss = 1'b0;
    @(negedge clk);
    miss_vld = 1'b0; hit_vld = 1'b0;
    check_val("R12", "victim with hit", int'(victim_way), 0);
    stamp[7][0] = tnow; tnow++;
    do_miss(7, 16'h0000, 1'b1, 1'b0, "R12 hit ignored", 1);
    do_miss(10, 16'h0000, 1'b1, 1'b0, "R12 untouched set", 0);
  endtask

  task automatic t_mixed;
    logic [15:0] cfgs [8];
    cfgs[0] = 16'h0000; cfgs[1] = 16'h0001; cfgs[2] = 16'h0100; cfgs[3] = 16'h0101;
    cfgs[4] = 16'h0003; cfgs[5] = 16'h0300; cfgs[6] = 16'h0303; cfgs[7] = 16'h0203;
    for (int n = 0; n < 600; n++) begin
      int s;
      int c;
      s = $urandom_range(0, NSETS - 1);
      c = $urandom_range(0, 7);
      if ($urandom_range(0, 2) == 0) do_hit(s, $urandom_range(0, 3));
      else do_miss(s, cfgs[c], 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R4 mixed");
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int s = 0; s < NSETS; s++)
      for (int w = 0; w < 4; w++) stamp[s][w] = w;
    tnow = 4;
    rst_n = 1'b1; ctrl_word = '0; lock_en = 1'b0; miss_vld = 1'b0;
    pref_miss = 1'b0; set_idx = '0; hit_vld = 1'b0; hit_way = '0;
    #2 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_disabled;
    t_hit_order;
    t_pin2;
    t_pin3;
    t_pin_both;
    t_steer2;
    t_steer3;
    t_clash;
    t_sets;
    t_mixed;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule